// File: doc/BRIEF.md
# Multiplexed-Address DRAM Front End

This block is a clocked, synthesizable model of the control side of a one-bit-wide dynamic memory whose cell address arrives in two halves over one shared address bus. All strobes are active low and are sampled on the rising edge of `clk`. The falling edge of the row strobe latches the row half. Each later falling edge of the column strobe, while the row strobe is held low, latches a column half and starts an access to the cell chosen by the two halves together. Holding the row strobe low across several column strobes walks the columns of one open row, which is fast page operation.

The level of the write-enable line when the column strobe falls sets the cycle type. A high level starts a read. The output turns on a fixed number of clocks later and keeps the cell's value until the column strobe goes high. A low level starts an early write. The input bit is stored at once and the output never turns on. If write-enable instead falls later in a read cycle, the input bit is stored on that edge, while the output keeps the value that was read before the write. This covers both read-modify-write and write-enable-timed writes. A row strobe pulse with no column strobe is a refresh-only cycle. It changes no cell and leaves the output off.

The three-state output appears as a data bit `dout` and its drive enable `dout_en`. A low `dout_en` stands for high impedance. Storage is a behavioural array whose depth is a parameter, so simulation can use a small configuration.

Top module: `mux_dram_front`

## Requirements
- R1: On a rising clock edge where `ras_n` is sampled low after being high on the previous edge, `addr` is latched as the row address. It stays latched until the next such edge.
- R2: On an edge where `cas_n` is sampled low after being high, and `ras_n` is low, `addr` is latched as the column address. The accessed cell index is {row[ROW_IDX-1:0], column[COL_IDX-1:0]}, with row bits above column bits, ROW_IDX = DEPTH_BITS/2 and COL_IDX = DEPTH_BITS - ROW_IDX.
- R3: If `we_n` is high on that column edge k, the cycle is a read. `dout_en` stays low after edges k to k+ACC_CYC-1 and is high after edge k+ACC_CYC, with `dout` equal to the addressed cell.
- R4: After any edge where `cas_n` is sampled high, `dout_en` is low.
- R5: Once a read's output is on, it keeps the same value while `cas_n` stays low, even when `ras_n` has returned high.
- R6: If `we_n` is low on the column edge (early write), `din` is stored in the addressed cell on that edge. `dout_en` stays low until `cas_n` rises.
- R7: In a read cycle, an edge that samples `we_n` falling while `ras_n` is low stores `din` in the addressed cell. `dout` keeps showing the value the cell held before that write.
- R8: While `ras_n` stays low, each new column strobe accesses a new column of the same latched row, with no new row strobe.
- R9: A `ras_n` low pulse during which `cas_n` stays high keeps `dout_en` low and changes no cell.
- R10: Whenever `dout_en` is low, `dout` is 0.
- R11: While `rst_n` is low, `dout_en` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all strobes and data |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low; also gates the output |
| we_n | input | 1 | Write enable, active low; high selects read |
| addr | input | ADDR_W | Shared row/column address bus |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when not driven |
| dout_en | output | 1 | Output drive enable; low means high impedance |

## Verification
The assertions assume that the strobe inputs change only between clock edges and keep one level for each whole sampled cycle. They also assume that a column access always begins with `ras_n` already low on an earlier edge. The bench drives every input on the falling clock edge. It opens a row before each column strobe and returns `cas_n` high for at least one edge between page accesses, so every column access starts from a clean rising-then-falling strobe.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_EARLY = 2'd2,
        CYC_LATE  = 2'd3
    } cyc_e;
endpackage

// File: rtl/mdr_edge.sv
module mdr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fell
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_n;
    end

    assign fell = prev_q & ~pin_n;
endmodule

// File: rtl/mdr_cell_array.sv
module mdr_cell_array #(
    parameter int DEPTH_BITS = 8
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [DEPTH_BITS-1:0] wr_idx,
    input  logic                  wr_bit,
    input  logic [DEPTH_BITS-1:0] rd_idx,
    output logic                  rd_bit
);
    localparam int CELLS = 1 << DEPTH_BITS;

    logic cells_q [CELLS];

    always_ff @(posedge clk) begin
        if (wr_en) cells_q[wr_idx] <= wr_bit;
    end

    assign rd_bit = cells_q[rd_idx];
endmodule

// File: rtl/mux_dram_front.sv
module mux_dram_front
    import mdr_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DEPTH_BITS = 8,
    parameter int ACC_CYC    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic              dout,
    output logic              dout_en
);
    localparam int ROW_IDX = DEPTH_BITS / 2;
    localparam int COL_IDX = DEPTH_BITS - ROW_IDX;
    localparam int CNT_W   = $clog2(ACC_CYC + 1);
    localparam int NSTB    = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        cyc_e              cyc;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic              rd_bit;
    } state_t;

    state_t st_q, st_d;

    // strobe falling-edge detection, one detector per strobe
    logic [NSTB-1:0] pins;
    logic [NSTB-1:0] fell;
    assign pins = {we_n, cas_n, ras_n};

    for (genvar i = 0; i < NSTB; i++) begin : g_edge
        mdr_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_n (pins[i]),
            .fell  (fell[i])
        );
    end

    logic ras_fell, cas_fell, we_fell;
    assign ras_fell = fell[0];
    assign cas_fell = fell[1];
    assign we_fell  = fell[2];

    // array access
    logic                  wr_en;
    logic [DEPTH_BITS-1:0] wr_idx;
    logic [DEPTH_BITS-1:0] new_idx;
    logic [DEPTH_BITS-1:0] cur_idx;
    logic                  arr_bit;
    logic [ADDR_W-1:0]     row_sel;

    assign row_sel = ras_fell ? addr : st_q.row;
    assign new_idx = {row_sel[ROW_IDX-1:0], addr[COL_IDX-1:0]};
    assign cur_idx = {st_q.row[ROW_IDX-1:0], st_q.col[COL_IDX-1:0]};

    mdr_cell_array #(.DEPTH_BITS(DEPTH_BITS)) u_cells (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_bit (din),
        .rd_idx (new_idx),
        .rd_bit (arr_bit)
    );

    always_comb begin
        st_d   = st_q;
        wr_en  = 1'b0;
        wr_idx = cur_idx;

        if (ras_fell) st_d.row = addr;

        if (cas_n) begin
            // column strobe inactive: output floats, cycle ends
            st_d.cyc   = CYC_IDLE;
            st_d.valid = 1'b0;
            st_d.cnt   = '0;
        end else if (cas_fell && !ras_n) begin
            st_d.col   = addr;
            st_d.valid = 1'b0;
            if (!we_n) begin
                st_d.cyc = CYC_EARLY;
                wr_en    = 1'b1;
                wr_idx   = new_idx;
            end else begin
                st_d.cyc    = CYC_READ;
                st_d.cnt    = CNT_W'(ACC_CYC - 1);
                st_d.rd_bit = arr_bit;
            end
        end else begin
            if ((st_q.cyc == CYC_READ || st_q.cyc == CYC_LATE) && !st_q.valid) begin
                if (st_q.cnt == '0) st_d.valid = 1'b1;
                else                st_d.cnt   = st_q.cnt - 1'b1;
            end
            if (st_q.cyc == CYC_READ && we_fell && !ras_n) begin
                st_d.cyc = CYC_LATE;
                wr_en    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{row: '0, col: '0, cyc: CYC_IDLE, cnt: '0, valid: 1'b0, rd_bit: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_en = st_q.valid;
    assign dout    = st_q.valid & st_q.rd_bit;
endmodule

// File: rtl/mdr_chk.sv
module mdr_chk (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic dout,
    input logic dout_en
);
    // R4
    cas_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_n |=> !dout_en);

    // R6
    early_wr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !ras_n && !we_n && $past(cas_n)) |=> !dout_en);

    // R3
    drive_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> !$past(cas_n));

    // R5
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en)) |-> $stable(dout));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> !dout);
endmodule

bind mux_dram_front mdr_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/mux_dram_front_bench.sv
module mux_dram_front_bench;
    localparam int ADDR_W  = 9;
    localparam int DBITS   = 8;
    localparam int ACC     = 3;
    localparam int NROW    = 16;
    localparam int NCOL    = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1;
    logic              cas_n = 1'b1;
    logic              we_n  = 1'b1;
    logic [ADDR_W-1:0] addr  = '0;
    logic              din   = 1'b0;
    logic              dout;
    logic              dout_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit exp_mem [NROW*NCOL];

    always #2 clk = ~clk;

    mux_dram_front #(.ADDR_W(ADDR_W), .DEPTH_BITS(DBITS), .ACC_CYC(ACC)) u_mux_dram_front (
        .clk     (clk),
        .rst_n   (rst_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic bit pat(input int r, input int c);
        return bit'((((r * 5 + c * 3) >> 1) & 1) ^ ((r == c) ? 1 : 0));
    endfunction

    task automatic open_row(input int r);
        addr  = ADDR_W'(r);
        ras_n = 1'b0;
        tick();
    endtask

    task automatic close_row();
        ras_n = 1'b1;
        tick();
    endtask

    task automatic early_wr(input int r, input int c, input bit b);
        addr = ADDR_W'(c);
        din  = b;
        we_n = 1'b0;
        cas_n = 1'b0;
        tick();
        chk("R6", dout_en, 1'b0);
        tick();
        chk("R6", dout_en, 1'b0);
        cas_n = 1'b1;
        we_n  = 1'b1;
        tick();
        exp_mem[r * NCOL + c] = b;
    endtask

    task automatic rd(input int r, input int c);
        addr  = ADDR_W'(c);
        we_n  = 1'b1;
        cas_n = 1'b0;
        repeat (ACC) tick();
        chk("R3", dout_en, 1'b0);
        tick();
        chk("R3", dout_en, 1'b1);
        chk("R2", dout, exp_mem[r * NCOL + c]);
        cas_n = 1'b1;
        tick();
        chk("R4", dout_en, 1'b0);
        chk("R10", dout, 1'b0);
    endtask

    task automatic late_wr(input int r, input int c, input bit b);
        bit old;
        old   = exp_mem[r * NCOL + c];
        addr  = ADDR_W'(c);
        we_n  = 1'b1;
        cas_n = 1'b0;
        repeat (ACC + 1) tick();
        chk("R7", dout, old);
        din  = b;
        we_n = 1'b0;
        tick();
        chk("R7", dout_en, 1'b1);
        chk("R7", dout, old);
        tick();
        chk("R7", dout, old);
        cas_n = 1'b1;
        we_n  = 1'b1;
        tick();
        exp_mem[r * NCOL + c] = b;
    endtask

    initial begin
        repeat (3) tick();
        // R11
        chk("R11", dout_en, 1'b0);
        chk("R11", dout, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R11", dout_en, 1'b0);

        // early writes over every cell, page mode per row (R8, R1)
        for (int r = 0; r < NROW; r++) begin
            open_row(r);
            for (int c = 0; c < NCOL; c++) early_wr(r, c, pat(r, c));
            close_row();
        end

        // read back every cell in page mode (R8, R2, R3)
        for (int r = 0; r < NROW; r++) begin
            open_row(r);
            for (int c = 0; c < NCOL; c++) rd(r, c);
            close_row();
        end

        // refresh-only pulse (R9)
        for (int r = 0; r < NROW; r += 5) begin
            addr  = ADDR_W'(r);
            din   = 1'b1;
            ras_n = 1'b0;
            for (int k = 0; k < 4; k++) begin
                tick();
                chk("R9", dout_en, 1'b0);
            end
            ras_n = 1'b1;
            tick();
            chk("R9", dout_en, 1'b0);
            open_row(r);
            for (int c = 0; c < NCOL; c++) rd(r, c);
            close_row();
        end

        // read-modify-write inverting rows 3 and 12 (R7)
        for (int r = 3; r < NROW; r += 9) begin
            open_row(r);
            for (int c = 0; c < NCOL; c++) late_wr(r, c, ~exp_mem[r * NCOL + c]);
            close_row();
            open_row(r);
            for (int c = 0; c < NCOL; c++) rd(r, c);
            close_row();
        end

        // output holds after row strobe rises (R5)
        for (int c = 0; c < NCOL; c += 3) begin
            open_row(7);
            addr  = ADDR_W'(c);
            cas_n = 1'b0;
            repeat (ACC + 1) tick();
            chk("R5", dout_en, 1'b1);
            ras_n = 1'b1;
            tick();
            chk("R5", dout_en, 1'b1);
            chk("R5", dout, exp_mem[7 * NCOL + c]);
            tick();
            chk("R5", dout, exp_mem[7 * NCOL + c]);
            cas_n = 1'b1;
            tick();
            chk("R4", dout_en, 1'b0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule